// File: doc/BRIEF.md
# Compare-Match Timer with Auto-Clear

This block is a 16-bit up-counter that advances by one on each cycle in which an external count-enable pulse (`tick`) is high. A 16-bit compare register is checked against the counter on every cycle. When a tick arrives while the two are equal, a compare flag is raised. In auto-clear mode, that same tick returns the counter to zero. Outside that case, a tick at all ones wraps the counter to zero and raises an overflow flag. Each flag has its own enable, which gates it onto its own interrupt request output. Either flag drops on a software clear strobe or on an interrupt acknowledge strobe.

Software loads the counter and the compare value with full-width parallel write strobes. A counter write beats any tick in the same cycle. It also arms a small guard state machine that discards the compare match of the next tick, however long that tick takes to arrive. This lets software park the counter on the compare value without raising a spurious event.

The guard has two states. In `GRD_ARMED`, matches count. In `GRD_BLOCKED`, the next match is discarded. The transitions are:

- *block*: any counter write moves the guard from either state to `GRD_BLOCKED`.
- *release*: a tick with no write moves it from `GRD_BLOCKED` to `GRD_ARMED`.
- *hold*: in all other cycles the guard keeps its state.

The counter path picks one of four actions each cycle: `ACT_LOAD`, `ACT_HOLD`, `ACT_ZERO` or `ACT_INC`.

Top module: `cmt_timer`

## Requirements
- R1: After reset, the outputs are as follows: `count` is 0, `cmp_val` is 0xFFFF, the guard is in `GRD_ARMED`, and both flags and both interrupt requests are 0.
- R2: On a cycle with `tick`=1 and no counter write, `count` rises by one at the next edge, unless R4 applies. On a cycle with `tick`=0 and no counter write, `count` holds.
- R3: A tick at `count`=0xFFFF that is not an auto-clear (R4) wraps `count` to 0 and sets `ovf_flag` at that edge. An auto-clear at 0xFFFF does not set `ovf_flag`.
- R4: With `auto_clr`=1, a tick while `count` equals `cmp_val` loads 0 into `count`.
- R5: A tick while `count` equals `cmp_val` and the guard is armed sets `cmp_flag` at that edge. Equality without a tick sets nothing.
- R6: With `cnt_wr`=1, `count` takes `cnt_wdata` at the next edge, whatever `tick` and `auto_clr` are. A tick in the same cycle neither counts nor raises a compare event.
- R7: After a counter write, the first following tick without a write raises no compare event, even if `count` equals `cmp_val` and even after many idle cycles. Later matching ticks raise it again.
- R8: `cmp_clr` or `cmp_ack` clears `cmp_flag`, and `ovf_clr` or `ovf_ack` clears `ovf_flag`. A set in the same cycle wins over a clear.
- R9: `cmp_irq` is `cmp_flag` AND `cmp_ie`, and `ovf_irq` is `ovf_flag` AND `ovf_ie`. The two requests are independent of each other.
- R10: With `cmp_wr`=1, `cmp_val` takes `cmp_wdata` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable pulse |
| auto_clr | input | 1 | 1 = clear the counter on a compare match |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | Compare register write value |
| cmp_ie | input | 1 | Compare interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cmp_clr | input | 1 | Software clear of the compare flag |
| ovf_clr | input | 1 | Software clear of the overflow flag |
| cmp_ack | input | 1 | Compare interrupt acknowledge |
| ovf_ack | input | 1 | Overflow interrupt acknowledge |
| count | output | 16 | Counter value |
| cmp_val | output | 16 | Compare register value |
| cmp_flag | output | 1 | Compare flag |
| ovf_flag | output | 1 | Overflow flag |
| cmp_irq | output | 1 | Masked compare interrupt request |
| ovf_irq | output | 1 | Masked overflow interrupt request |

## Verification
A guard left stuck in `GRD_BLOCKED` shows up as a `cmp_flag` that stays low on the next matching tick. A guard that is never set shows up as a flag rising on the very tick after a write of the compare value. Both faults are visible one edge after that tick. A wrong counter action shows up on `count` one edge after the offending cycle: a load that loses to a tick, a zero instead of an increment, or a missed wrap. Timing both flags against a cycle-accurate reference, across mixed writes, ticks and clears, exposes a set/clear priority error on the first cycle where the two collide.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;

    // Interrupt source indices
    localparam int SRC_OVF = 0;
    localparam int SRC_CMP = 1;
    localparam int SRC_N   = 2;

    // Match guard states
    typedef enum logic [0:0] {
        GRD_ARMED   = 1'b0,
        GRD_BLOCKED = 1'b1
    } grd_state_e;

    // Counter action chosen each cycle
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_INC  = 2'd2,
        ACT_ZERO = 2'd3
    } cnt_act_e;

endpackage

// File: rtl/cmt_counter.sv
`timescale 1ns/1ps
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         auto_clr,
    input  logic         match,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] ONE = W'(1);

    cnt_act_e act;

    // Action select: write beats tick, compare clear beats increment
    always_comb begin
        if (wr)                       act = ACT_LOAD;
        else if (!tick)               act = ACT_HOLD;
        else if (auto_clr && match)   act = ACT_ZERO;
        else                          act = ACT_INC;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: count <= wdata;
                ACT_HOLD: count <= count;
                ACT_ZERO: count <= '0;
                ACT_INC:  count <= count + ONE;
                default:  count <= count;
            endcase
        end
    end

    // Roll-over only on a true increment past all ones
    assign wrap = (act == ACT_INC) && (count == TOP);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr) |=> $stable(count)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && !(auto_clr && match)) |=> (count == $past(count) + ONE)); // R2
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (count == $past(wdata))); // R6
    AST_CNT_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && auto_clr && match) |=> (count == '0)); // R4

endmodule

// File: rtl/cmt_guard.sv
`timescale 1ns/1ps
module cmt_guard
    import cmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic wr,
    input  logic match,
    output logic hit
);
    grd_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= GRD_ARMED;
        else        state <= nxt;
    end

    // block: any write; release: tick without write
    always_comb begin
        nxt = state;
        unique case (state)
            GRD_ARMED:   nxt = wr ? GRD_BLOCKED : GRD_ARMED;
            GRD_BLOCKED: begin
                if (wr)        nxt = GRD_BLOCKED;
                else if (tick) nxt = GRD_ARMED;
                else           nxt = GRD_BLOCKED;
            end
            default:     nxt = GRD_ARMED;
        endcase
    end

    // Compare event is qualified by the state
    always_comb begin
        hit = 1'b0;
        unique case (state)
            GRD_ARMED:   hit = tick && match && !wr;
            GRD_BLOCKED: hit = 1'b0;
            default:     hit = 1'b0;
        endcase
    end

    AST_GRD_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (state == GRD_BLOCKED)); // R7
    AST_GRD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GRD_BLOCKED && tick && !wr) |=> (state == GRD_ARMED)); // R7
    AST_GRD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GRD_BLOCKED && !tick) |=> (state == GRD_BLOCKED)); // R7

endmodule

// File: rtl/cmt_flag.sv
`timescale 1ns/1ps
module cmt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag); // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag); // R8
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set) |=> $stable(flag)); // R8

endmodule

// File: rtl/cmt_timer.sv
`timescale 1ns/1ps
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             auto_clr,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cmp_ie,
    input  logic             ovf_ie,
    input  logic             cmp_clr,
    input  logic             ovf_clr,
    input  logic             cmp_ack,
    input  logic             ovf_ack,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp_val,
    output logic             cmp_flag,
    output logic             ovf_flag,
    output logic             cmp_irq,
    output logic             ovf_irq
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic             match;
    logic             wrap;
    logic             hit;
    logic [SRC_N-1:0] set_v, clr_v, flag_v, ie_v;

    // Compare register
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_val <= TOP;
        else if (cmp_wr) cmp_val <= cmp_wdata;
    end

    assign match = (count == cmp_val);

    cmt_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .auto_clr (auto_clr),
        .match    (match),
        .wr       (cnt_wr),
        .wdata    (cnt_wdata),
        .count    (count),
        .wrap     (wrap)
    );

    cmt_guard u_grd (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr    (cnt_wr),
        .match (match),
        .hit   (hit)
    );

    assign set_v[SRC_OVF] = wrap;
    assign set_v[SRC_CMP] = hit;
    assign clr_v[SRC_OVF] = ovf_clr | ovf_ack;
    assign clr_v[SRC_CMP] = cmp_clr | cmp_ack;
    assign ie_v[SRC_OVF]  = ovf_ie;
    assign ie_v[SRC_CMP]  = cmp_ie;

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        cmt_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_v[i]),
            .clr   (clr_v[i]),
            .flag  (flag_v[i])
        );
    end

    assign ovf_flag = flag_v[SRC_OVF];
    assign cmp_flag = flag_v[SRC_CMP];
    assign ovf_irq  = flag_v[SRC_OVF] & ie_v[SRC_OVF];
    assign cmp_irq  = flag_v[SRC_CMP] & ie_v[SRC_CMP];

    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count == TOP && !(auto_clr && match)) |=> (ovf_flag && count == '0)); // R3
    AST_NO_OVF_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && auto_clr && match && !ovf_flag && !wrap) |=> !ovf_flag); // R3
    AST_CMP_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && match && !$past(cnt_wr) && $past(tick)) |=> cmp_flag); // R5
    AST_NO_HIT_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && $past(cnt_wr) && !cmp_flag) |=> !cmp_flag); // R7
    AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> (cmp_val == $past(cmp_wdata))); // R10
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_ie |-> !cmp_irq) and (!ovf_ie |-> !ovf_irq)); // R9

endmodule

// File: tb/cmt_timer_test.sv
`timescale 1ns/1ps
module cmt_timer_test;

    localparam int W = 16;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cmp;
        logic         cf;
        logic         of;
        logic         blk;
    } mdl_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0, auto_clr = 1'b0, cnt_wr = 1'b0, cmp_wr = 1'b0;
    logic [W-1:0] cnt_wdata = '0, cmp_wdata = '0;
    logic         cmp_ie = 1'b0, ovf_ie = 1'b0, cmp_clr = 1'b0, ovf_clr = 1'b0;
    logic         cmp_ack = 1'b0, ovf_ack = 1'b0;
    logic [W-1:0] count, cmp_val;
    logic         cmp_flag, ovf_flag, cmp_irq, ovf_irq;

    int unsigned checks = 0;
    int unsigned errors = 0;
    bit          done = 1'b0;
    mdl_t        m;

    always #4 clk = ~clk;

    cmt_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .auto_clr(auto_clr),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .cmp_ie(cmp_ie), .ovf_ie(ovf_ie), .cmp_clr(cmp_clr), .ovf_clr(ovf_clr),
        .cmp_ack(cmp_ack), .ovf_ack(ovf_ack), .count(count), .cmp_val(cmp_val),
        .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
    );

    // Reference step taken from the requirements
    function automatic mdl_t next_state(mdl_t s);
        mdl_t n = s;
        logic eq = (s.cnt == s.cmp);
        logic cset = 1'b0;
        logic oset = 1'b0;
        if (cnt_wr) begin
            n.cnt = cnt_wdata;
            n.blk = 1'b1;
        end else if (tick) begin
            if (auto_clr && eq) n.cnt = '0;
            else begin
                n.cnt = s.cnt + 16'd1;
                if (s.cnt == 16'hFFFF) oset = 1'b1;
            end
            if (eq && !s.blk) cset = 1'b1;
            n.blk = 1'b0;
        end
        if (cmp_wr) n.cmp = cmp_wdata;
        n.cf = cset ? 1'b1 : ((cmp_clr || cmp_ack) ? 1'b0 : s.cf);
        n.of = oset ? 1'b1 : ((ovf_clr || ovf_ack) ? 1'b0 : s.of);
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m <= '{cnt: '0, cmp: 16'hFFFF, cf: 1'b0, of: 1'b0, blk: 1'b0};
        else        m <= next_state(m);
    end

    task automatic chk(input string req, input string what, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2", "count", count, m.cnt);
        chk("R10", "cmp_val", cmp_val, m.cmp);
        chk("R5", "cmp_flag", 16'(cmp_flag), 16'(m.cf));
        chk("R3", "ovf_flag", 16'(ovf_flag), 16'(m.of));
        chk("R9", "cmp_irq", 16'(cmp_irq), 16'(m.cf & cmp_ie));
        chk("R9", "ovf_irq", 16'(ovf_irq), 16'(m.of & ovf_ie));
    endtask

    task automatic idle();
        tick = 0; cnt_wr = 0; cmp_wr = 0; cmp_clr = 0; ovf_clr = 0;
        cmp_ack = 0; ovf_ack = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "count", count, 16'h0000);
        chk("R1", "cmp_val", cmp_val, 16'hFFFF);
        chk("R1", "flags", {14'd0, cmp_flag, ovf_flag}, 16'd0);
        chk("R1", "irqs", {14'd0, cmp_irq, ovf_irq}, 16'd0);

        // R10 compare load
        cmp_wr = 1; cmp_wdata = 16'd5; cyc(); idle();
        chk("R10", "cmp_val", cmp_val, 16'd5);
        // R6 write beats tick
        cnt_wr = 1; cnt_wdata = 16'd3; tick = 1; cyc(); idle();
        chk("R6", "count", count, 16'd3);
        tick = 1; cyc(); chk("R2", "count inc", count, 16'd4);
        tick = 0; cyc(); chk("R2", "count hold", count, 16'd4);
        tick = 1; cyc(); chk("R5", "flag before match tick", 16'(cmp_flag), 16'd0);
        cyc(); chk("R5", "flag after match tick", 16'(cmp_flag), 16'd1);
        chk("R2", "count past match", count, 16'd6);
        idle();
        cmp_ie = 1; cyc(); chk("R9", "cmp_irq on", 16'(cmp_irq), 16'd1);
        cmp_ie = 0; cyc(); chk("R9", "cmp_irq masked", 16'(cmp_irq), 16'd0);
        cmp_clr = 1; cyc(); idle(); chk("R8", "sw clear", 16'(cmp_flag), 16'd0);

        // R7 blocked match while stopped
        cnt_wr = 1; cnt_wdata = 16'd5; cyc(); idle();
        repeat (6) cyc();
        tick = 1; cyc(); idle();
        chk("R7", "blocked match", 16'(cmp_flag), 16'd0);
        chk("R7", "count after blocked", count, 16'd6);
        cnt_wr = 1; cnt_wdata = 16'd4; cyc(); idle();
        tick = 1; cyc(); cyc(); idle();
        chk("R7", "match rearmed", 16'(cmp_flag), 16'd1);

        // R8 ack and set-over-clear
        cmp_ack = 1; cyc(); idle(); chk("R8", "ack clear", 16'(cmp_flag), 16'd0);
        cnt_wr = 1; cnt_wdata = 16'd4; cyc(); idle();
        tick = 1; cyc();
        cmp_ack = 1; cyc(); idle();
        chk("R8", "set beats clear", 16'(cmp_flag), 16'd1);

        // R4 auto-clear
        cmp_clr = 1; auto_clr = 1; cmp_wr = 1; cmp_wdata = 16'd2;
        cnt_wr = 1; cnt_wdata = 16'd0; cyc(); idle();
        tick = 1; cyc(); cyc(); cyc(); idle();
        chk("R4", "auto clear", count, 16'd0);
        chk("R5", "flag on clear", 16'(cmp_flag), 16'd1);

        // R3 wrap and overflow
        auto_clr = 0; ovf_ie = 1; cnt_wr = 1; cnt_wdata = 16'hFFFE; cyc(); idle();
        tick = 1; cyc(); cyc(); idle();
        chk("R3", "wrap count", count, 16'd0);
        chk("R3", "ovf set", 16'(ovf_flag), 16'd1);
        chk("R9", "ovf_irq", 16'(ovf_irq), 16'd1);
        ovf_clr = 1; auto_clr = 1; cmp_wr = 1; cmp_wdata = 16'hFFFF;
        cnt_wr = 1; cnt_wdata = 16'hFFFE; cyc(); idle();
        tick = 1; cyc(); cyc(); idle();
        chk("R4", "clear at top", count, 16'd0);
        chk("R3", "no ovf on clear", 16'(ovf_flag), 16'd0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            tick     = $urandom_range(1, 0) == 1;
            cnt_wr   = $urandom_range(15, 0) == 0;
            cmp_wr   = $urandom_range(63, 0) == 0;
            cmp_clr  = $urandom_range(7, 0) == 0;
            cmp_ack  = $urandom_range(11, 0) == 0;
            ovf_clr  = $urandom_range(7, 0) == 0;
            ovf_ack  = $urandom_range(11, 0) == 0;
            if ($urandom_range(31, 0) == 0) auto_clr = ~auto_clr;
            if ($urandom_range(15, 0) == 0) cmp_ie = ~cmp_ie;
            if ($urandom_range(15, 0) == 0) ovf_ie = ~ovf_ie;
            case ($urandom_range(2, 0))
                0:       cnt_wdata = 16'($urandom_range(12, 0));
                1:       cnt_wdata = 16'hFFF4 + 16'($urandom_range(11, 0));
                default: cnt_wdata = 16'($urandom);
            endcase
            cmp_wdata = ($urandom_range(1, 0) == 0) ? 16'($urandom_range(12, 0))
                                                    : 16'hFFF8 + 16'($urandom_range(7, 0));
            cyc();
        end
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule